// File: doc/BRIEF.md
# Sequential Booth-Recoded Signed Multiplier

This block multiplies two signed two's complement operands over several clock cycles and returns a double-width signed product, split into an upper and a lower half. It accepts one request at a time through a valid/ready handshake and returns the result through a second valid/ready handshake. The multiplicand is held fixed. The multiplier is loaded into the lower half of a combined accumulator, with one guard bit below it. In each step the block inspects the lowest multiplier bit together with the bit just shifted past it. If the pair opens a run of ones, the multiplicand is subtracted from the upper half. If it closes a run, the multiplicand is added. Inside a run of zeros or a run of ones nothing is added. The whole accumulator then shifts right by one place, and the sign of the upper half is copied into the vacated top position.

The upper half carries one extra bit of headroom. This lets the most negative multiplicand be subtracted without wrapping. After exactly WIDTH steps, the low 2*WIDTH bits of the accumulator hold the product. Handshake rules: a request transfers on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from acceptance until the result has been taken. A result transfers on an edge where `rsp_valid` and `rsp_ready` are both high. While `rsp_ready` is low, the result is held unchanged. The consumer can therefore apply back-pressure for as long as it needs, and no new request is taken during that time.

Top module: `booth_mul_seq`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` is 0, and the two are never high in the same cycle.
- R2: Once a request is accepted, `req_ready` is 0 until the result handshake completes. A `req_valid` raised while `req_ready` is 0 is ignored and does not change the pending result.
- R3: `rsp_valid` goes high exactly WIDTH clock edges after the edge that accepted the request.
- R4: `{rsp_hi, rsp_lo}` equals the signed 2*WIDTH-bit product of `req_mcand` and `req_mplier`, both read as two's complement, for any operand signs.
- R5: The most negative value times the most negative value gives the positive product 2^(2*WIDTH-2). The same holds for the other extremes, such as the most negative value times -1 or times the most positive value.
- R6: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_hi` and `rsp_lo` stay unchanged. On the edge that completes the handshake, `rsp_valid` drops and `req_ready` returns to 1.
- R7: The multiplier bit pair (current bit, bit to its right, where the first step uses a right-hand bit of 0) selects the action: 10 subtracts the multiplicand from the upper half, 01 adds it, and 00 or 11 only shift.
- R8: A zero operand on either side gives a zero product, and multiplying by 1 returns the sign-extended multiplicand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request operands are present |
| req_ready | output | 1 | Block can accept a request |
| req_mcand | input | WIDTH | Signed multiplicand |
| req_mplier | input | WIDTH | Signed multiplier |
| rsp_valid | output | 1 | Product is present |
| rsp_ready | input | 1 | Consumer takes the product |
| rsp_hi | output | WIDTH | Upper half of the signed product |
| rsp_lo | output | WIDTH | Lower half of the signed product |

## Verification
Several properties are checked by assertions on every cycle. The ready and valid flags never overlap. The ready flag drops after an acceptance. A held result stays stable under back-pressure. A 00 or 11 pair only shifts the upper half arithmetically. The step counter advances by one per step. The finished accumulator never needs its headroom bit. Other properties can only be shown by the bench's scenarios: that the product value is correct for random and extreme operands, the exact latency, and that a request raised during a computation leaves the result unchanged.

// File: rtl/booth_pkg.sv
package booth_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } mul_state_t;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } booth_op_t;
endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic      cur_bit,
  input  logic      right_bit,
  output booth_op_t op
);
  // R7: 10 opens a run (subtract), 01 closes a run (add), 00/11 shift only
  always_comb begin
    unique case ({cur_bit, right_bit})
      2'b10:   op = OP_SUB;
      2'b01:   op = OP_ADD;
      default: op = OP_NONE;
    endcase
  end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic signed [WIDTH:0]   acc,
  input  logic        [WIDTH-1:0] mcand,
  input  booth_op_t               op,
  output logic signed [WIDTH:0]   sum
);
  logic signed [WIDTH:0] mcand_ext;

  assign mcand_ext = {mcand[WIDTH-1], mcand};

  always_comb begin
    unique case (op)
      OP_ADD:  sum = acc + mcand_ext;
      OP_SUB:  sum = acc - mcand_ext;
      default: sum = acc;
    endcase
  end
endmodule

// File: rtl/booth_step_counter.sv
module booth_step_counter #(
  parameter int STEPS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic en,
  output logic last
);
  localparam int CW = $clog2(STEPS + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (en)    cnt <= cnt + CW'(1);
  end

  assign last = (cnt == CW'(STEPS - 1));

  assert_step_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clear && !last) |=> (cnt == $past(cnt) + CW'(1)));

  assert_step_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt < CW'(STEPS)));
endmodule

// File: rtl/booth_mul_seq.sv
module booth_mul_seq
  import booth_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [WIDTH-1:0] req_mcand,
  input  logic [WIDTH-1:0] req_mplier,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [WIDTH-1:0] rsp_hi,
  output logic [WIDTH-1:0] rsp_lo
);
  mul_state_t            state;
  logic signed [WIDTH:0] upper;
  logic [WIDTH-1:0]      lower;
  logic                  guard;
  logic [WIDTH-1:0]      mcand_q;
  booth_op_t             step_op;
  logic signed [WIDTH:0] upper_next;
  logic                  last_step;
  logic                  accept;
  logic                  running;

  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_DONE);
  assign accept    = req_valid && req_ready;
  assign running   = (state == ST_RUN);
  assign rsp_hi    = upper[WIDTH-1:0];
  assign rsp_lo    = lower;

  booth_recode u_recode (
    .cur_bit   (lower[0]),
    .right_bit (guard),
    .op        (step_op)
  );

  booth_addsub #(.WIDTH(WIDTH)) u_addsub (
    .acc   (upper),
    .mcand (mcand_q),
    .op    (step_op),
    .sum   (upper_next)
  );

  booth_step_counter #(.STEPS(WIDTH)) u_steps (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (accept),
    .en    (running),
    .last  (last_step)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      upper   <= '0;
      lower   <= '0;
      guard   <= 1'b0;
      mcand_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          upper   <= '0;
          lower   <= req_mplier;
          guard   <= 1'b0;
          mcand_q <= req_mcand;
          state   <= ST_RUN;
        end
        ST_RUN: begin
          guard <= lower[0];
          lower <= {upper_next[0], lower[WIDTH-1:1]};
          upper <= upper_next >>> 1;
          if (last_step) state <= ST_DONE;
        end
        ST_DONE: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_no_overlap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && rsp_valid));

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_hold_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hi) && $stable(rsp_lo)));

  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> (req_ready && !rsp_valid));

  assert_shift_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && (lower[0] == guard)) |=> (upper == ($past(upper) >>> 1)));

  assert_fits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (upper[WIDTH] == upper[WIDTH-1]));
endmodule

// File: tb/booth_mul_seq_test.sv
module booth_mul_seq_test;
  localparam int W = 32;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [W-1:0] req_mcand = '0;
  logic [W-1:0] req_mplier = '0;
  logic         rsp_valid;
  logic         rsp_ready = 1'b0;
  logic [W-1:0] rsp_hi;
  logic [W-1:0] rsp_lo;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  booth_mul_seq #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_mcand(req_mcand), .req_mplier(req_mplier),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_hi(rsp_hi), .rsp_lo(rsp_lo)
  );

  function automatic logic [2*W-1:0] ref_product(input logic [W-1:0] a, input logic [W-1:0] b);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    return 64'(sa * sb);
  endfunction

  task automatic check(input string req, input logic [2*W-1:0] got, input logic [2*W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // one transaction; intrude raises a stray request mid-run, hold applies back-pressure
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input string tag, input bit intrude, input int hold);
    int n;
    logic [2*W-1:0] held;
    @(negedge clk);
    check("R2 ready before request", {63'd0, req_ready}, 64'd1);
    req_valid  = 1'b1;
    req_mcand  = a;
    req_mplier = b;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 200) begin
      if (intrude && n == 3) begin
        check("R2 not ready while busy", {63'd0, req_ready}, 64'd0);
        req_valid  = 1'b1;
        req_mcand  = ~a;
        req_mplier = b + 1;
      end
      @(negedge clk);
      req_valid = 1'b0;
      n++;
    end
    check("R3 latency", 64'(n), 64'(W));
    check(tag, {rsp_hi, rsp_lo}, ref_product(a, b));
    held = {rsp_hi, rsp_lo};
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check("R6 held under back-pressure", {63'd0, rsp_valid}, 64'd1);
      check("R6 stable result", {rsp_hi, rsp_lo}, held);
    end
    if (intrude)
      check("R2 stray request ignored", {rsp_hi, rsp_lo}, ref_product(a, b));
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check("R6 release", {62'd0, rsp_valid, req_ready}, 64'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] minv, maxv;
    minv = {1'b1, {(W-1){1'b0}}};
    maxv = {1'b0, {(W-1){1'b1}}};
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 reset state", {62'd0, req_ready, rsp_valid}, 64'd2);
    rst_n = 1'b1;

    run_op(32'd6, 32'd3, "R4 small positive", 1'b0, 0);
    run_op(minv, minv, "R5 min times min", 1'b0, 2);
    run_op(minv, '1, "R5 min times -1", 1'b0, 0);
    run_op(maxv, minv, "R5 max times min", 1'b0, 0);
    run_op(maxv, maxv, "R5 max times max", 1'b0, 0);
    run_op(32'd0, 32'hDEADBEEF, "R8 zero multiplicand", 1'b0, 0);
    run_op(32'h8765_4321, 32'd0, "R8 zero multiplier", 1'b0, 0);
    run_op(32'hFFFF_FFF9, 32'd1, "R8 times one", 1'b1, 3);
    run_op(32'd2, 32'h0000_0073, "R7 runs of ones 0b1110011", 1'b0, 0);
    run_op(32'd5, 32'hAAAA_AAAA, "R7 alternating pairs", 1'b0, 0);
    run_op(32'hFFFF_FFFD, '1, "R7 all-ones multiplier", 1'b0, 0);
    run_op(32'hFFFF_FFF4, 32'h7, "R4 negative times positive", 1'b0, 0);

    for (int k = 0; k < 40; k++)
      run_op($urandom, $urandom, "R4 random operands", (k % 7) == 0, k % 3);

    finish_run();
  end
endmodule